// File: doc/BRIEF.md
# Cascadable Parallel-Load Serial-Out Shift Register

This block turns parallel words into a bit-serial stream. It has one or more 8-bit register stages, set by a parameter. On an enabled rising clock edge, an active-low load select picks between two actions. One is to capture the whole parallel bus at once. The other is to move every bit one place towards the top of its stage, with a new bit entering at the bottom from the serial input. The top bit of each stage feeds the bottom of the next. Only the top bit of the last stage is visible, as the serial output.

An active-low clock enable freezes the register while it is high. It is a synchronous enable on a free-running clock, so no gated clock exists anywhere in the block. An active-low master reset clears every bit at once, without waiting for a clock edge. Its release is synchronised inside the block, so the first edge that can change the register is well defined.

Top module: `piso_chain`

## Requirements
- R1: While `rstN` is low, every register bit is 0 and `serOut` is 0, at once and without a clock edge.
- R2: After `rstN` rises, the first two rising clock edges leave the register at all zeros, whatever the other inputs do. The third rising edge is the first that can load or shift.
- R3: On a rising edge with `clkEnN` high, the register keeps its contents and `serOut` does not change, whatever `loadN`, `parIn` and `serIn` do.
- R4: On a rising edge with `clkEnN` low and `loadN` low, stage k takes `parIn[8k+7:8k]`, with bus bit 8k+i going to position i. After that edge, `serOut` equals `parIn[8*STAGES-1]`.
- R5: On a rising edge with `clkEnN` low and `loadN` high, `serIn` enters position 0 of stage 0. Every bit moves up one position, and position 7 of stage k moves into position 0 of stage k+1. A bit entered at `serIn` reaches `serOut` after 8*STAGES shifts.
- R6: `serOut` is position 7 of the last stage. After a load, successive shifts present `parIn` from its top bit down to bit 0.
- R7: A reset that arrives in the middle of a shift sequence clears the output before the next clock edge. A reset held across an edge with a load requested still leaves the register at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, rising edge active |
| rstN | input | 1 | Master reset, active low. Asserts asynchronously; release is synchronised |
| clkEnN | input | 1 | Clock enable, active low; high holds the register |
| loadN | input | 1 | Load select, active low: low loads, high shifts |
| parIn | input | 8*STAGES | Parallel data; bits 8k+7..8k go to stage k |
| serIn | input | 1 | Serial data into position 0 of stage 0 |
| serOut | output | 1 | Position 7 of the last stage |

## Verification
The bench walks the output across a load and the complete 16-bit shift-out. A design that reversed the bit order, or loaded the stages in swapped order, would present the stream backwards or in half-swapped form. A single 1 is sent through `serIn` and must appear after exactly sixteen shifts, neither one shift earlier nor one later, so a broken link between the stages or an off-by-one shift shows up. The bench checks that hold ignores both load and shift requests. It drops reset between clock edges in the middle of a stream, where a synchronous-only clear would leave the output high. It requests a load during the two ignored edges after release, where a design without release synchronisation would load too early.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } pisoStrobe_t;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkEnN,
  input  logic        loadN,
  output logic        rstSyncN,
  output pisoStrobe_t strobe
);
  logic syncStage;

  // async assertion, release after two clock edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage <= 1'b0;
      rstSyncN  <= 1'b0;
    end else begin
      syncStage <= 1'b1;
      rstSyncN  <= syncStage;
    end
  end

  always_comb begin
    strobe.load  = !clkEnN && !loadN;
    strobe.shift = !clkEnN &&  loadN;
  end
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2,
  localparam int TOTAL = WIDTH * STAGES
) (
  input  logic             clk,
  input  logic             rstSyncN,
  input  pisoStrobe_t      strobe,
  input  logic [TOTAL-1:0] parIn,
  input  logic             serIn,
  output logic [TOTAL-1:0] chainBits
);
  logic [WIDTH-1:0] stageQ   [STAGES];
  logic             stageSin [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stageSin[k] = serIn;
    end else begin : g_link
      assign stageSin[k] = stageQ[k-1][WIDTH-1];
    end

    always_ff @(posedge clk or negedge rstSyncN) begin
      if (!rstSyncN) begin
        stageQ[k] <= '0;
      end else if (strobe.load) begin
        stageQ[k] <= parIn[k*WIDTH +: WIDTH];
      end else if (strobe.shift) begin
        stageQ[k] <= {stageQ[k][WIDTH-2:0], stageSin[k]};
      end
    end

    assign chainBits[k*WIDTH +: WIDTH] = stageQ[k];
  end
endmodule

// File: rtl/piso_chain.sv
module piso_chain
  import piso_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2,
  localparam int TOTAL = WIDTH * STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnN,
  input  logic             loadN,
  input  logic [TOTAL-1:0] parIn,
  input  logic             serIn,
  output logic             serOut
);
  pisoStrobe_t      strobe;
  logic             rstSyncN;
  logic [TOTAL-1:0] chainBits;

  piso_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEnN   (clkEnN),
    .loadN    (loadN),
    .rstSyncN (rstSyncN),
    .strobe   (strobe)
  );

  piso_datapath #(.WIDTH(WIDTH), .STAGES(STAGES)) u_datapath (
    .clk       (clk),
    .rstSyncN  (rstSyncN),
    .strobe    (strobe),
    .parIn     (parIn),
    .serIn     (serIn),
    .chainBits (chainBits)
  );

  assign serOut = chainBits[TOTAL-1];
endmodule

// File: rtl/piso_chain_checker.sv
module piso_chain_checker #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2,
  localparam int TOTAL = WIDTH * STAGES
) (
  input logic             clk,
  input logic             rstN,
  input logic             rstSyncN,
  input logic             clkEnN,
  input logic             loadN,
  input logic [TOTAL-1:0] parIn,
  input logic             serIn,
  input logic [TOTAL-1:0] chainBits
);
  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEARS: assert (chainBits == '0); // R1
      AST_RESET_OVERRIDES: assert (!rstSyncN); // R7
    end
  end

  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstSyncN) |-> $past(rstN, 2)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(chainBits)); // R3

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (rstSyncN && !clkEnN && !loadN) |=> chainBits == $past(parIn)); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (rstSyncN && !clkEnN && loadN) |=>
      chainBits == {$past(chainBits[TOTAL-2:0]), $past(serIn)}); // R5
endmodule

bind piso_chain piso_chain_checker #(.WIDTH(WIDTH), .STAGES(STAGES)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .rstSyncN  (rstSyncN),
  .clkEnN    (clkEnN),
  .loadN     (loadN),
  .parIn     (parIn),
  .serIn     (serIn),
  .chainBits (chainBits)
);

// File: tb/test_piso_chain.sv
module test_piso_chain;
  localparam int CLK_PERIOD = 10;
  localparam int TOTAL = 16;
  localparam int NVEC = 11;

  // {clkEnN, loadN, serIn, parIn[15:0], expected serOut}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 16'hA5C3, 1'b1},  // R4 load, top bit 1
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0},  // R5 -> 4B86
    {1'b0, 1'b1, 1'b1, 16'h0000, 1'b1},  // R5 -> 970D
    {1'b1, 1'b0, 1'b0, 16'hFFFF, 1'b1},  // R3 hold ignores load
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0},  // R5 -> 2E1A
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0},  // R5 -> 5C34
    {1'b0, 1'b1, 1'b1, 16'h0000, 1'b1},  // R5 -> B869
    {1'b0, 1'b0, 1'b1, 16'h0180, 1'b0},  // R4 load 0180
    {1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b0},  // R3 hold ignores shift
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0},  // R5 -> 0300
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0}   // R5 -> 0600
  };

  logic clk = 1'b0;
  logic rstN, clkEnN, loadN, serIn;
  logic [TOTAL-1:0] parIn;
  logic serOut;
  int checks = 0;
  int errors = 0;

  piso_chain i_piso_chain (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN),
    .parIn(parIn), .serIn(serIn), .serOut(serOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: serOut=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    rstN = 1'b0; clkEnN = 1'b1; loadN = 1'b1; serIn = 1'b0; parIn = '0;
    @(negedge clk); @(negedge clk);
    check(serOut, 1'b0, "R1 reset state");

    // R2: load requested during the ignored edges after release
    clkEnN = 1'b0; loadN = 1'b0; parIn = 16'hFFFF;
    rstN = 1'b1;
    step(); check(serOut, 1'b0, "R2 first edge after release ignored");
    step(); check(serOut, 1'b0, "R2 second edge after release ignored");
    step(); check(serOut, 1'b1, "R2 third edge loads");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      clkEnN = VEC[i][19]; loadN = VEC[i][18]; serIn = VEC[i][17];
      parIn = VEC[i][16:1];
      step();
      check(serOut, VEC[i][0], $sformatf("R3/R4/R5 vector %0d", i));
    end

    // R6: full shift-out order
    clkEnN = 1'b0; loadN = 1'b0; parIn = 16'hC5A3; serIn = 1'b0;
    step();
    check(serOut, parIn[15], "R6 first bit after load");
    loadN = 1'b1;
    for (int k = 1; k < TOTAL; k++) begin
      step();
      check(serOut, 16'hC5A3 >> (15 - k), $sformatf("R6 bit %0d", 15 - k));
    end

    // R5: single 1 travels through both stages
    loadN = 1'b0; parIn = '0;
    step();
    loadN = 1'b1; serIn = 1'b1;
    step();
    serIn = 1'b0;
    for (int k = 2; k < TOTAL; k++) step();
    check(serOut, 1'b0, "R5 one shift short of chain length");
    step();
    check(serOut, 1'b1, "R5 bit arrives after 16 shifts");

    // R3: hold keeps a 1 on the output over several edges
    clkEnN = 1'b1; loadN = 1'b0; parIn = '0; serIn = 1'b0;
    step(); step();
    check(serOut, 1'b1, "R3 hold ignores load of zeros");

    // R7: async clear mid-shift
    clkEnN = 1'b0; loadN = 1'b0; parIn = 16'hFFFF;
    step();
    loadN = 1'b1; serIn = 1'b1;
    step(); step();
    check(serOut, 1'b1, "R7 output high before clear");
    #2 rstN = 1'b0;
    #1 check(serOut, 1'b0, "R7 clear without clock edge");
    loadN = 1'b0;
    step();
    check(serOut, 1'b0, "R1 reset overrides load");
    rstN = 1'b1;
    step(); step();
    check(serOut, 1'b0, "R2 edges ignored after second release");
    step();
    check(serOut, 1'b1, "R4 load after second release");

    summary();
  end
endmodule